// File: doc/BRIEF.md
# DCC Serial Access Port

This block picks the data communication channel bytes out of a received SONET/SDH byte stream and sends them out serially, one bit per pulse of a gapped clock enable. The caller presents each received overhead byte with its row and column index. Two mode inputs choose which channel bytes are taken: the line channel (nine bytes, D4 to D12) or the section channel (three bytes, D1 to D3). With neither mode input set, the port is in full-access mode, which this block does not implement, so it stays silent.

For each frame, the serial stream carries a parity byte first and then that frame's channel bytes. The parity byte protects the channel bytes of the frame before it. Each of its bits is the parity of the matching bit position across those bytes, and a control input picks even or odd polarity. Extracted bytes go into a small FIFO. A serialiser drains the FIFO at a fixed gapped rate, so the output rate does not depend on where the bytes sit in the frame. The rate divider is slower in section mode, which matches that mode's smaller payload.

Top module: `dcc_serial_port`

## Requirements
- R1: `modeLine`=1 selects line mode, even when `modeSection` is also 1. `modeSection`=1 with `modeLine`=0 selects section mode. With both at 0 the port is idle: `serClkEn` stays 0, and the FIFO and parity state are cleared.
- R2: A valid byte with `inRow`=0 and `inCol`=0 marks a frame start. At that point a parity byte is queued ahead of the new frame's channel bytes.
- R3: In line mode the channel bytes are those at rows 5, 6 and 7, columns 0, 1 and 2. They are sent in arrival order: row by row, and by column within a row.
- R4: In section mode the channel bytes are those at row 2, columns 0, 1 and 2, sent in arrival order.
- R5: The parity byte is the bitwise XOR of all channel bytes queued since the previous frame start. It is inverted when `parityEven`=0. The first parity byte after the port becomes active covers no bytes, so it is 0x00 when even and 0xFF when odd.
- R6: Each byte is sent MSB first. Every bit is presented on `serData` in the same cycle as one `serClkEn` pulse.
- R7: `serFrameStart` pulses only together with the first bit of a parity byte.
- R8: Consecutive `serClkEn` pulses are at least LINE_DIV cycles apart in line mode and SECT_DIV cycles apart in section mode. When bytes are waiting, the pulses come exactly that far apart.
- R9: Channel bytes that arrive while the serialiser is busy wait in the FIFO. None is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inByte | input | 8 | Received overhead byte |
| inValid | input | 1 | inByte, inRow and inCol are valid this cycle |
| inRow | input | 4 | Row index of the byte within the frame (0..8) |
| inCol | input | 4 | Overhead column index of the byte |
| modeLine | input | 1 | Select line channel bytes D4..D12 |
| modeSection | input | 1 | Select section channel bytes D1..D3 |
| parityEven | input | 1 | 1: even parity byte, 0: odd |
| serData | output | 1 | Serial data, valid with serClkEn |
| serClkEn | output | 1 | One-cycle pulse per serial bit |
| serFrameStart | output | 1 | Marks the first bit of each parity byte |

## Verification
On every cycle, the assertions check four things: the FIFO never takes a write when it is full, the frame marker never appears without a clock pulse, an idle port leaves the FIFO empty, and two clock pulses never fall on adjacent cycles. The scoreboard scenarios are needed for everything else. They show which row and column positions are taken in each mode, the line-over-section priority, the parity values under both polarities, MSB-first order, and that the pulse spacing exactly matches each mode's divider.

// File: rtl/dcc_port_pkg.sv
package dcc_port_pkg;
  // strobes from the control path to the datapath
  typedef struct packed {
    logic pushData;  // write a channel byte into the FIFO
    logic pushPar;   // write the parity byte, restart accumulation
    logic load;      // pop FIFO head into the shifter
    logic shift;     // emit one serial bit
    logic firstBit;  // the emitted bit is bit 7 of its byte
    logic flush;     // port idle: clear all state
  } dccStrobe_t;
endpackage

// File: rtl/dcc_port_ctl.sv
module dcc_port_ctl
  import dcc_port_pkg::*;
#(
  parameter int LINE_DIV = 4,
  parameter int SECT_DIV = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [3:0] inRow,
  input  logic [3:0] inCol,
  input  logic       modeLine,
  input  logic       modeSection,
  input  logic       fifoEmpty,
  output dccStrobe_t strobe
);
  localparam int MAX_DIV = (LINE_DIV > SECT_DIV) ? LINE_DIV : SECT_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam logic [DIV_W-1:0] LINE_LIM = DIV_W'(LINE_DIV - 1);
  localparam logic [DIV_W-1:0] SECT_LIM = DIV_W'(SECT_DIV - 1);

  logic             active;
  logic             inDcc;
  logic             inStart;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic             tick;
  logic             busy;
  logic [2:0]       bitCnt;

  assign active  = modeLine | modeSection;
  assign inStart = inValid && (inRow == 4'd0) && (inCol == 4'd0);
  assign inDcc   = inValid && (inCol < 4'd3) &&
                   (modeLine ? (inRow >= 4'd5 && inRow <= 4'd7) : (inRow == 4'd2));
  assign divLim  = modeLine ? LINE_LIM : SECT_LIM;
  assign tick    = (divCnt >= divLim);

  always_comb begin
    strobe          = '0;
    strobe.flush    = !active;
    strobe.pushPar  = active && inStart;
    strobe.pushData = active && inDcc;
    strobe.load     = active && !busy && !fifoEmpty;
    strobe.shift    = active && busy && tick;
    strobe.firstBit = (bitCnt == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      divCnt <= '0;
      busy   <= 1'b0;
      bitCnt <= '0;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (strobe.load) begin
        busy   <= 1'b1;
        bitCnt <= '0;
      end else if (strobe.shift) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) busy <= 1'b0;
      end
    end
  end

  // R8: serial pulses never on adjacent cycles
  a_r8_pulse_gap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> !strobe.shift);

  initial begin
    if (LINE_DIV < 2 || SECT_DIV < 2) $error("dividers must be at least 2");
  end
endmodule

// File: rtl/dcc_port_dp.sv
module dcc_port_dp
  import dcc_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       parityEven,
  input  dccStrobe_t strobe,
  output logic       fifoEmpty,
  output logic       serData,
  output logic       serClkEn,
  output logic       serFrameStart
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(FIFO_DEPTH - 1);

  logic [8:0]       mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic [7:0]       parAcc;
  logic [7:0]       shReg;
  logic             shPar;
  logic             wrEn;
  logic [8:0]       wrWord;

  assign wrEn      = strobe.pushData | strobe.pushPar;
  assign wrWord    = strobe.pushPar ? {1'b1, parAcc ^ {8{~parityEven}}}
                                    : {1'b0, inByte};
  assign fifoEmpty = (count == '0);

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      parAcc <= '0;
    end else begin
      if (wrEn)        wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (strobe.load) rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({wrEn, strobe.load})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.pushPar)       parAcc <= '0;
      else if (strobe.pushData) parAcc <= parAcc ^ inByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      shReg         <= '0;
      shPar         <= 1'b0;
      serData       <= 1'b0;
      serClkEn      <= 1'b0;
      serFrameStart <= 1'b0;
    end else begin
      serClkEn      <= strobe.shift;
      serFrameStart <= strobe.shift && shPar && strobe.firstBit;
      if (strobe.load) begin
        shReg <= mem[rdPtr][7:0];
        shPar <= mem[rdPtr][8];
      end else if (strobe.shift) begin
        serData <= shReg[7];
        shReg   <= {shReg[6:0], 1'b0};
      end
    end
  end

  // R9: a write never meets a full FIFO
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (int'(count) < FIFO_DEPTH) || strobe.load);
  // R7: frame marker only together with a bit pulse
  a_r7_start_with_clk: assert property (@(posedge clk) disable iff (!rstN)
    serFrameStart |-> serClkEn);
  // R1: idle port leaves the FIFO empty
  a_r1_idle_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> fifoEmpty);
endmodule

// File: rtl/dcc_serial_port.sv
module dcc_serial_port #(
  parameter int LINE_DIV   = 4,
  parameter int SECT_DIV   = 10,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inValid,
  input  logic [3:0] inRow,
  input  logic [3:0] inCol,
  input  logic       modeLine,
  input  logic       modeSection,
  input  logic       parityEven,
  output logic       serData,
  output logic       serClkEn,
  output logic       serFrameStart
);
  import dcc_port_pkg::*;

  dccStrobe_t strobe;
  logic       fifoEmpty;

  dcc_port_ctl #(.LINE_DIV(LINE_DIV), .SECT_DIV(SECT_DIV)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRow(inRow), .inCol(inCol),
    .modeLine(modeLine), .modeSection(modeSection), .fifoEmpty(fifoEmpty),
    .strobe(strobe)
  );

  dcc_port_dp #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .parityEven(parityEven),
    .strobe(strobe), .fifoEmpty(fifoEmpty), .serData(serData),
    .serClkEn(serClkEn), .serFrameStart(serFrameStart)
  );
endmodule

// File: tb/dcc_serial_port_tb.sv
module dcc_serial_port_tb;
  localparam int LDIV = 4;
  localparam int SDIV = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0;
  logic [3:0] inRow = '0, inCol = '0;
  logic       modeLine = 1'b0, modeSection = 1'b0, parityEven = 1'b0;
  logic       serData, serClkEn, serFrameStart;

  always #10 clk = ~clk;

  dcc_serial_port #(.LINE_DIV(LDIV), .SECT_DIV(SDIV), .FIFO_DEPTH(16)) u_dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .inRow(inRow), .inCol(inCol), .modeLine(modeLine),
    .modeSection(modeSection), .parityEven(parityEven),
    .serData(serData), .serClkEn(serClkEn), .serFrameStart(serFrameStart)
  );

  int nChecks = 0, nFails = 0;
  logic [8:0] expQ[$];
  logic [7:0] benchAcc = '0;
  int   cyc = 0, lastPulse = 0, minGap = 1000000, pulseCount = 0;
  bit   havePulse = 0;
  int   bitIdx = 0;
  logic [7:0] rxByte = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rstN && serClkEn) begin
      pulseCount++;
      if (havePulse && (cyc - lastPulse) < minGap) minGap = cyc - lastPulse;
      lastPulse = cyc;
      havePulse = 1;
      if (expQ.size() == 0) begin
        check(0, "R9 unexpected bit", 1, 0);
      end else begin
        if (bitIdx == 0)
          check(serFrameStart == expQ[0][8], "R7 frame marker on first bit",
                serFrameStart, expQ[0][8]);
        else
          check(serFrameStart == 1'b0, "R7 marker only on first bit", serFrameStart, 0);
        rxByte = {rxByte[6:0], serData};
        bitIdx++;
        if (bitIdx == 8) begin
          check(rxByte == expQ[0][7:0],
                expQ[0][8] ? "R5 parity byte" : "R3/R4/R6 channel byte",
                rxByte, expQ[0][7:0]);
          void'(expQ.pop_front());
          bitIdx = 0;
        end
      end
    end
  end

  function automatic bit isDcc(input int r, input int c);
    if (!(modeLine || modeSection) || c > 2) return 0;
    if (modeLine) return (r >= 5 && r <= 7);
    return (r == 2);
  endfunction

  task automatic sendFrame(input int fr);
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < 4; c++) begin
        logic [7:0] b;
        b = 8'(fr * 37 + r * 11 + c * 5 + 8'h5A);
        if (modeLine || modeSection) begin
          if (r == 0 && c == 0) begin  // R2: parity queued at frame start
            expQ.push_back({1'b1, benchAcc ^ {8{~parityEven}}});
            benchAcc = '0;
          end
          if (isDcc(r, c)) begin
            expQ.push_back({1'b0, b});
            benchAcc ^= b;
          end
        end
        inByte  = b;
        inRow   = 4'(r);
        inCol   = 4'(c);
        inValid = 1'b1;
        @(negedge clk);
        inValid = 1'b0;
        repeat (9) @(negedge clk);
      end
    end
  endtask

  task automatic drain(input string req);
    int t;
    t = 0;
    while (expQ.size() != 0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(expQ.size() == 0, req, expQ.size(), 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic setMode(input logic ml, input logic ms, input logic pe);
    modeLine = 1'b0; modeSection = 1'b0;
    repeat (4) @(negedge clk);
    benchAcc = '0;
    bitIdx = 0;
    havePulse = 0;
    minGap = 1000000;
    parityEven = pe; modeLine = ml; modeSection = ms;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(serClkEn == 0 && serFrameStart == 0 && serData == 0, "R1 reset outputs",
          {serClkEn, serFrameStart, serData}, 0);

    // R1: idle mode emits nothing
    pulseCount = 0;
    sendFrame(0);
    sendFrame(1);
    check(pulseCount == 0, "R1 idle port silent", pulseCount, 0);

    // line mode, odd parity
    setMode(1'b1, 1'b0, 1'b0);
    for (int f = 0; f < 3; f++) sendFrame(10 + f);
    drain("R9 line mode drained");
    check(minGap == LDIV, "R8 line pulse spacing", minGap, LDIV);

    // section mode, even parity
    setMode(1'b0, 1'b1, 1'b1);
    for (int f = 0; f < 3; f++) sendFrame(20 + f);
    drain("R9 section mode drained");
    check(minGap == SDIV, "R8 section pulse spacing", minGap, SDIV);

    // both set: line priority, odd parity
    setMode(1'b1, 1'b1, 1'b0);
    for (int f = 0; f < 2; f++) sendFrame(30 + f);
    drain("R1 line priority drained");
    check(minGap == LDIV, "R1 priority uses line rate", minGap, LDIV);

    // back to idle: outputs stay quiet
    setMode(1'b0, 1'b0, 1'b0);
    pulseCount = 0;
    sendFrame(40);
    check(pulseCount == 0, "R1 idle after activity", pulseCount, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule